// File: doc/BRIEF.md
# Random Allocation Tag Generator

The block picks a 4-bit allocation tag for a 64-bit pointer and writes it into the pointer's tag field, bits [59:56]. A 16-value tag ring is walked one step per clock. Tag values set in a 16-bit exclusion mask are passed over, so the chosen tag is always one the caller allows, unless every value is excluded.

There are two operations. A random request takes its start tag and a 16-bit seed from an internal state register. A 16-bit linear feedback shift register advances the seed four times, and the four feedback bits form the step count. When the tag is chosen, the state register is rewritten with the new tag and the advanced seed. An offset request takes its start tag from the pointer's own tag field and its step count from a 4-bit immediate. It also adds a signed address offset to the pointer.

Requests use a valid/ready handshake, and a one-cycle done pulse marks the result. While the block is idle, software can load the state register to seed the generator.

Top module: `alloc_tag_gen`

## Requirements
- R1: The exclusion mask is 16 bits, and bit k excludes tag value k. A random request (op_i=0) uses op_mask_i OR ctl_mask_i. An offset request (op_i=1) uses ctl_mask_i alone and ignores op_mask_i.
- R2: If all 16 exclusion bits are set, the result tag is 0, whatever the start tag or step count.
- R3: With a step count of 0, the result is the start tag if that tag is not excluded. Otherwise it is the first non-excluded value found by counting up modulo 16 from the start tag.
- R4: With a step count of n>0, the walk is done n times. Each time, the tag is incremented modulo 16 at least once and then keeps incrementing while it is excluded. The result is the last tag reached.
- R5: A random request takes its step count from four LFSR steps on the seed held in state bits [23:8]. In step i (0..3), fb = s[5]^s[3]^s[2]^s[0], the seed becomes {fb, s[15:1]}, and fb is written into bit i of the step count.
- R6: When a random request completes, the state register becomes {advanced seed, 4'b0000, result tag}. Bits [23:8] hold the seed, [7:4] are zero and [3:0] hold the tag. An offset request leaves the state register unchanged.
- R7: An offset request takes its start tag from ptr_i[59:56]. The result is ptr_i plus the sign-extended 16-bit addr_ofs_i, with bits [59:56] replaced by the result tag.
- R8: A random request returns ptr_i with only bits [59:56] replaced by the result tag. It uses the state's low nibble as the start tag.
- R9: req_ready_o is high only when the block is idle and done_o is low. done_o is a one-cycle pulse, and result_o is valid while done_o is high. A request presented while req_ready_o is low is ignored.
- R10: Asynchronous reset (rst_ni low) clears the state register to 0, drives req_ready_o high and drives done_o low.
- R11: A state write (state_we_i) loads state_wdata_i into the state register only while req_ready_o is high. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block ready to accept a request |
| op_i | input | 1 | Operation: 0 random, 1 offset |
| ptr_i | input | 64 | Source pointer |
| op_mask_i | input | 16 | Exclusion mask from the operand |
| ctl_mask_i | input | 16 | Exclusion mask from the control register |
| addr_ofs_i | input | 16 | Signed address offset (offset mode) |
| tag_ofs_i | input | 4 | Step count immediate (offset mode) |
| state_we_i | input | 1 | State register write enable |
| state_wdata_i | input | 24 | State register write data |
| state_o | output | 24 | State register contents |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 64 | Tagged pointer |

## Verification
The in-line assertions check, on every cycle, that done_o is a single-cycle pulse and that the block is never ready during it. They also check that a completed walk never lands on an excluded tag unless the whole mask is set, that an all-excluded walk returns 0, that no walk runs longer than the bounded number of steps, and that the state register only changes on a completed random request or an idle write. Only the bench scenarios can show that the exact tag sequence and step count are right: the skips across wrap-around, a multi-lap walk with most values excluded, and the LFSR-derived steps and seed. The same holds for the signed address addition and for requests and state writes being ignored while the block is busy.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;
  localparam int TAG_W    = 4;
  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int SEED_W   = 16;
  localparam int SEED_LSB = 8;
  localparam int STATE_W  = SEED_LSB + SEED_W;

  typedef enum logic {
    OP_RANDOM = 1'b0,
    OP_OFFSET = 1'b1
  } tag_op_e;
endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [STEPS-1:0]  step_o
);
  logic [SEED_W-1:0] chain [STEPS+1];

  assign chain[0] = seed_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb           = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
    assign chain[g+1]   = {fb, chain[g][SEED_W-1:1]};
    assign step_o[g]    = fb;
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/tag_walker.sv
module tag_walker
  import tag_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic [TAG_W-1:0]  steps_i,
  input  logic [NUM_TAGS-1:0] mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int MAX_WALK = NUM_TAGS * NUM_TAGS;
  localparam int CNT_W    = $clog2(MAX_WALK + 2);

  logic                busy_q, done_q, must_inc_q;
  logic [TAG_W-1:0]    tag_q, rem_q;
  logic [NUM_TAGS-1:0] mask_q;
  logic                all_excl;

  assign all_excl = &mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      must_inc_q <= 1'b0;
      tag_q      <= '0;
      rem_q      <= '0;
      mask_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q     <= 1'b1;
        tag_q      <= start_tag_i;
        mask_q     <= mask_i;
        must_inc_q <= (steps_i != '0);
        rem_q      <= (steps_i == '0) ? '0 : steps_i - 1'b1;
      end else if (busy_q) begin
        if (all_excl) begin
          tag_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (must_inc_q || mask_q[tag_q]) begin
          tag_q      <= tag_q + 1'b1;
          must_inc_q <= 1'b0;
        end else if (rem_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          // landed on an allowed tag; next step begins with a forced increment
          rem_q <= rem_q - 1'b1;
          tag_q <= tag_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tag_o  = tag_q;

  logic [CNT_W-1:0] walk_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    walk_cnt_q <= '0;
    else if (start_i && !busy_q)    walk_cnt_q <= '0;
    else if (busy_q)                walk_cnt_q <= walk_cnt_q + 1'b1;
  end

  p_walk_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_cnt_q <= CNT_W'(MAX_WALK));

  p_land_allowed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !all_excl) |-> !mask_q[tag_q]);

  p_all_excl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && all_excl) |-> (tag_q == '0));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/tag_ptr_adder.sv
module tag_ptr_adder #(
  parameter int PTR_W = 64,
  parameter int OFS_W = 16
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             add_en_i,
  output logic [PTR_W-1:0] sum_o
);
  logic [PTR_W-1:0] ofs_ext;
  assign ofs_ext = {{(PTR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign sum_o   = add_en_i ? ptr_i + ofs_ext : ptr_i;
endmodule

// File: rtl/tag_ptr_insert.sv
module tag_ptr_insert #(
  parameter int PTR_W   = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_comb begin
    ptr_o = ptr_i;
    ptr_o[TAG_LSB +: TAG_W] = tag_i;
  end
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen
  import tag_gen_pkg::*;
#(
  parameter int PTR_W      = 64,
  parameter int ADDR_OFS_W = 16,
  parameter int TAG_LSB    = 56,
  parameter int LFSR_STEPS = TAG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                op_i,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic [15:0]         op_mask_i,
  input  logic [15:0]         ctl_mask_i,
  input  logic [ADDR_OFS_W-1:0] addr_ofs_i,
  input  logic [3:0]          tag_ofs_i,
  input  logic                state_we_i,
  input  logic [23:0]         state_wdata_i,
  output logic [23:0]         state_o,
  output logic                done_o,
  output logic [PTR_W-1:0]    result_o
);
  logic [STATE_W-1:0]  state_q;
  logic [SEED_W-1:0]   seed_nx, seed_nx_q;
  logic [TAG_W-1:0]    lfsr_steps, start_tag, steps, tag;
  logic [NUM_TAGS-1:0] mask;
  logic [PTR_W-1:0]    base_ptr, ptr_q;
  tag_op_e             op, op_q;
  logic                busy, done, accept, idle;

  assign op     = tag_op_e'(op_i);
  assign idle   = !busy && !done;
  assign accept = req_valid_i && idle;

  tag_lfsr #(.SEED_W(SEED_W), .STEPS(LFSR_STEPS)) u_lfsr (
    .seed_i (state_q[SEED_LSB +: SEED_W]),
    .seed_o (seed_nx),
    .step_o (lfsr_steps)
  );

  always_comb begin
    if (op == OP_OFFSET) begin
      start_tag = ptr_i[TAG_LSB +: TAG_W];
      steps     = tag_ofs_i;
      mask      = ctl_mask_i;
    end else begin
      start_tag = state_q[TAG_W-1:0];
      steps     = lfsr_steps;
      mask      = ctl_mask_i | op_mask_i;
    end
  end

  tag_walker u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_tag_i (start_tag),
    .steps_i     (steps),
    .mask_i      (mask),
    .busy_o      (busy),
    .done_o      (done),
    .tag_o       (tag)
  );

  tag_ptr_adder #(.PTR_W(PTR_W), .OFS_W(ADDR_OFS_W)) u_adder (
    .ptr_i    (ptr_i),
    .ofs_i    (addr_ofs_i),
    .add_en_i (op == OP_OFFSET),
    .sum_o    (base_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      op_q      <= OP_RANDOM;
      seed_nx_q <= '0;
    end else if (accept) begin
      ptr_q     <= base_ptr;
      op_q      <= op;
      seed_nx_q <= seed_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      state_q <= '0;
    else if (done && op_q == OP_RANDOM)
      state_q <= {seed_nx_q, {(SEED_LSB-TAG_W){1'b0}}, tag};
    else if (state_we_i && idle)
      state_q <= state_wdata_i;
  end

  tag_ptr_insert #(.PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_insert (
    .ptr_i (ptr_q),
    .tag_i (tag),
    .ptr_o (result_o)
  );

  assign req_ready_o = idle;
  assign done_o      = done;
  assign state_o     = state_q;

  p_not_ready_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o);

  p_state_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(done && op_q == OP_RANDOM) && !(state_we_i && req_ready_o)) |=> $stable(state_q));

  p_offset_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && op_q == OP_OFFSET) |=> $stable(state_q));
endmodule

// File: tb/alloc_tag_gen_tb.sv
module alloc_tag_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        op = 1'b0;
  logic [63:0] ptr = '0;
  logic [15:0] op_mask = '0, ctl_mask = '0, addr_ofs = '0;
  logic [3:0]  tag_ofs = '0;
  logic        state_we = 1'b0;
  logic [23:0] state_wdata = '0;
  logic [23:0] state;
  logic        done;
  logic [63:0] result;

  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  alloc_tag_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .op_i(op), .ptr_i(ptr), .op_mask_i(op_mask), .ctl_mask_i(ctl_mask),
    .addr_ofs_i(addr_ofs), .tag_ofs_i(tag_ofs), .state_we_i(state_we),
    .state_wdata_i(state_wdata), .state_o(state), .done_o(done), .result_o(result)
  );

  // {start, steps, ctl_mask, expected tag, addr_ofs}
  localparam int NV = 9;
  localparam logic [NV-1:0][43:0] VEC = {
    {4'h3, 4'h0, 16'h0000, 4'h3, 16'h0010},  // R3 start allowed
    {4'h3, 4'h0, 16'h0008, 4'h4, 16'hFFE0},  // R3 start excluded
    {4'h3, 4'h2, 16'h0000, 4'h5, 16'h0010},  // R4 plain steps
    {4'h3, 4'h2, 16'h0010, 4'h6, 16'hFFE0},  // R4 skip one
    {4'hF, 4'h1, 16'h0001, 4'h1, 16'h0100},  // R4 wrap
    {4'h5, 4'h7, 16'hFFFF, 4'h0, 16'h0010},  // R2 all excluded
    {4'h2, 4'h1, 16'hFFFB, 4'h2, 16'h8000},  // R4 single allowed, full lap
    {4'h0, 4'hF, 16'h00FF, 4'hE, 16'h7FFF},  // R4 multi-lap
    {4'h6, 4'h1, 16'h0040, 4'h7, 16'h0001}   // R4 excluded start, one step
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] walk(input logic [3:0] t, input logic [3:0] n, input logic [15:0] m);
    if (m == 16'hFFFF) return 4'h0;
    if (n == 0) begin
      for (int k = 0; k < 16 && m[t]; k++) t = t + 1'b1;
    end else begin
      for (int s = 0; s < n; s++) begin
        t = t + 1'b1;
        for (int k = 0; k < 16 && m[t]; k++) t = t + 1'b1;
      end
    end
    return t;
  endfunction

  function automatic logic [23:0] rand_model(input logic [23:0] st, input logic [15:0] m);
    logic [15:0] sd = st[23:8];
    logic [3:0]  n = '0;
    logic        fb;
    for (int i = 0; i < 4; i++) begin
      fb = sd[5] ^ sd[3] ^ sd[2] ^ sd[0];
      sd = {fb, sd[15:1]};
      n[i] = fb;
    end
    return {sd, 4'h0, walk(st[3:0], n, m)};
  endfunction

  function automatic logic [63:0] put_tag(input logic [63:0] p, input logic [3:0] t);
    p[59:56] = t;
    return p;
  endfunction

  task automatic issue(input bit o, input logic [63:0] p, input logic [15:0] om,
                       input logic [15:0] cm, input logic [15:0] ao, input logic [3:0] to);
    @(negedge clk);
    op = o; ptr = p; op_mask = om; ctl_mask = cm; addr_ofs = ao; tag_ofs = to;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && !done; k++) @(negedge clk);
  endtask

  task automatic write_state(input logic [23:0] v);
    @(negedge clk);
    state_we = 1'b1; state_wdata = v;
    @(negedge clk);
    state_we = 1'b0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] p, expp;
    logic [23:0] st_before, exp_st;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(state == 24'h0, "R10 state", state, 0);
    check(req_ready == 1'b1, "R10 ready", req_ready, 1);
    check(done == 1'b0, "R10 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 idle write
    write_state(24'h123456);
    check(state == 24'h123456, "R11 idle write", state, 24'h123456);
    st_before = state;

    // R7 R4 R3 R2 R1 offset table, op_mask all ones must have no effect
    for (int i = 0; i < NV; i++) begin
      p = put_tag(64'h0A00_1234_5678_9AB0 + 64'(i) * 64'h1111, VEC[i][43:40]);
      issue(1'b1, p, 16'hFFFF, VEC[i][35:20], VEC[i][15:0], VEC[i][39:36]);
      wait_done();
      expp = put_tag(p + {{48{VEC[i][15]}}, VEC[i][15:0]}, VEC[i][19:16]);
      check(done && result == expp, "R7/R4/R1 offset vector", result, expp);
    end
    @(negedge clk);
    check(state == st_before, "R6 offset leaves state", state, st_before);

    // R5 R6 R8 hand-computed: seed 0x0001 -> steps 1, seed 0x1000
    write_state(24'h000100);
    p = 64'hF7A5_0000_DEAD_BEEF;
    issue(1'b0, p, 16'h0, 16'h0, 16'h1234, 4'h0);
    wait_done();
    check(done && result == put_tag(p, 4'h1), "R8 random pointer", result, put_tag(p, 4'h1));
    @(negedge clk);
    check(state == 24'h100001, "R5 R6 state update", state, 24'h100001);

    // R5 R1 random chain against model, OR of both masks
    write_state(24'hACE1_07);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] om = 16'h00F0 >> i;
      logic [15:0] cm = 16'h0F00 << i;
      exp_st = rand_model(state, om | cm);
      p = 64'h0123_4567_89AB_CDEF ^ 64'(i);
      issue(1'b0, p, om, cm, 16'h0, 4'h0);
      wait_done();
      check(done && result == put_tag(p, exp_st[3:0]), "R1 R5 random tag", result, put_tag(p, exp_st[3:0]));
      @(negedge clk);
      check(state == exp_st, "R6 random state", state, exp_st);
    end

    // R2 R1 masks split across both sources -> tag 0, seed still advances
    write_state(24'hBEEF_05);
    exp_st = rand_model(24'hBEEF05, 16'hFFFF);
    p = 64'h0F00_0000_0000_0000;
    issue(1'b0, p, 16'hFF00, 16'h00FF, 16'h0, 4'h0);
    wait_done();
    check(done && result == 64'h0000_0000_0000_0000, "R2 random all excluded", result, 0);
    @(negedge clk);
    check(state == exp_st, "R2 R6 seed advances", state, exp_st);

    // R9 R11 requests and state writes while busy are ignored
    p = put_tag(64'h1000_0000_0000_0000, 4'h0);
    issue(1'b1, p, 16'h0, 16'h00FF, 16'h0, 4'hF);
    check(req_ready == 1'b0, "R9 not ready while busy", req_ready, 0);
    op = 1'b1; ptr = 64'h5555_5555_5555_5555; ctl_mask = 16'h0; tag_ofs = 4'h0;
    req_valid = 1'b1; state_we = 1'b1; state_wdata = 24'hFFFFFF;
    @(negedge clk);
    req_valid = 1'b0; state_we = 1'b0;
    wait_done();
    check(result == put_tag(p, 4'hE), "R9 busy request ignored", result, put_tag(p, 4'hE));
    check(req_ready == 1'b0, "R9 not ready during done", req_ready, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
    check(state == exp_st, "R11 busy write ignored", state, exp_st);

    // R10 reset clears state again
    rst_n = 1'b0;
    @(negedge clk);
    check(state == 24'h0 && req_ready && !done, "R10 reset clears", state, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule